// File: doc/BRIEF.md
# Transmit History FIFO with Status Word

This block keeps a short log of the frames a CAN channel has sent. Each time the transmit engine finishes a frame it offers one record on a push port. The block stores up to DEPTH records in arrival order, and the host takes them back one at a time through a pop port. The oldest stored record is always shown on `pop_data`. A 16-bit status word reports the fill count, the full and empty conditions, a sticky overflow flag and a sticky interrupt flag. The host clears each sticky flag by writing 0 to its bit.

A four-state machine sets the fill condition. `ST_OFF` is the shut state: the channel is in reset mode or the log is disabled, and nothing is stored. `ST_EMPTY` means the log is enabled and holds no records. `ST_PART` means some records are held, but fewer than DEPTH. `ST_FULL` means DEPTH records are held.

The state transitions are:
- `GO_OFF`: from any state, when the channel is in reset mode or the log is disabled.
- `WAKE`: `ST_OFF` to `ST_EMPTY`, when the log is enabled and nothing is pushed.
- `FIRST`: `ST_OFF` or `ST_EMPTY` to `ST_PART`, on an accepted push.
- `FILL`: `ST_PART` to `ST_FULL`, on a push alone at DEPTH-1 records.
- `DRAIN`: `ST_PART` to `ST_EMPTY`, on a pop alone at one record.
- `UNFILL`: `ST_FULL` to `ST_PART`, on a pop.

The full and empty flags come from the state. The count comes from a separate counter.

Status word layout:

| Bits | Content |
|------|---------|
| 0 | empty flag |
| 1 | full flag |
| 2 | overflow flag |
| 3 | interrupt flag |
| 11:8 | number of unread records |
| 15:12 and 7:4 | always 0 |

DEPTH may be set from 2 to 15.

Top module: `txhist_fifo`

## Requirements
- R1: After reset the status word reads 0x0001, with only the empty flag (bit 0) set.
- R2: Records come out on `pop_data` in the order they were pushed, up to DEPTH (8 by default) of them. `pop_data` shows the oldest stored record, and a pop removes it at the next clock edge.
- R3: Bits 11:8 hold the number of unread records. A push and a pop in the same cycle, while the buffer is neither empty nor full, leave the count unchanged.
- R4: The full flag (bit 1) is 1 exactly while the count equals DEPTH. It drops to 0 as soon as the count falls below DEPTH.
- R5: The empty flag (bit 0) is 1 exactly while the count is 0. A pop on an empty buffer is ignored.
- R6: A push while DEPTH records are held is discarded, even if a pop happens in the same cycle. The discard sets the overflow flag (bit 2), and the stored records are left unchanged.
- R7: A pulse on `irq_event` sets the interrupt flag (bit 3) at the next clock edge.
- R8: The interrupt and overflow flags clear only when the host writes 0 to their bit. Writing 1 leaves them unchanged. If a set event and a host clear of the same flag fall in the same cycle, the set wins.
- R9: While `chan_rst` is high, the block discards all records and clears the count, the full flag, the interrupt flag and the overflow flag. It sets the empty flag, so the status word reads 0x0001.
- R10: While `enable` is low (and `chan_rst` is low), the buffer is emptied: count 0, full 0, empty 1. Pushes are ignored, and the interrupt and overflow flags keep their values.
- R11: Bits 15:12 and 7:4 always read 0. Host writes to those bits, to the count field and to bits 1:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Log enable; low empties the buffer |
| chan_rst | input | 1 | Channel reset mode; clears the buffer and all flags |
| push_valid | input | 1 | Transmit engine offers one record |
| push_data | input | DATA_W | Record to store |
| pop_req | input | 1 | Host removes the oldest record |
| pop_data | output | DATA_W | Oldest stored record |
| irq_event | input | 1 | Selected interrupt source fired |
| wr_en | input | 1 | Host write to the status word |
| wr_data | input | 16 | Host write data |
| status | output | 16 | Status word |

## Verification
The bench builds the block with its defaults: DEPTH of 8 and DATA_W of 16. With these values the full state is reached in eight pushes, so the full and overflow corners can each be reached directly and more than once in a short run. The 16-bit records are distinct enough to prove ordering across a wrap of the read and write pointers. The four-bit count field is wide enough to show every fill level from 0 to 8 unchanged.

// File: rtl/txhist_pkg.sv
package txhist_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } hist_state_e;

    localparam int STAT_W    = 16;
    localparam int B_EMPTY   = 0;
    localparam int B_FULL    = 1;
    localparam int B_OVF     = 2;
    localparam int B_IRQ     = 3;
    localparam int CNT_LSB   = 8;
    localparam int CNT_FIELD = 4;

endpackage

// File: rtl/txhist_store.sv
module txhist_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/txhist_ctrl.sv
module txhist_ctrl
    import txhist_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             chan_rst,
    input  logic             push_valid,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             drop,
    output logic             flush,
    output logic             st_full,
    output logic             st_empty,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    hist_state_e st_q, st_d;
    logic        shut;
    logic        room;
    logic        holds;

    assign shut = chan_rst | ~enable;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state: transitions named in the brief
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (shut)         st_d = ST_OFF;    // GO_OFF
                else if (push_ok) st_d = ST_PART;   // FIRST
                else              st_d = ST_EMPTY;  // WAKE
            end
            ST_EMPTY: begin
                if (shut)         st_d = ST_OFF;    // GO_OFF
                else if (push_ok) st_d = ST_PART;   // FIRST
            end
            ST_PART: begin
                if (shut)
                    st_d = ST_OFF;                  // GO_OFF
                else if (push_ok && !pop_ok && cnt == CNT_LAST)
                    st_d = ST_FULL;                 // FILL
                else if (pop_ok && !push_ok && cnt == CNT_W'(1))
                    st_d = ST_EMPTY;                // DRAIN
            end
            ST_FULL: begin
                if (shut)        st_d = ST_OFF;     // GO_OFF
                else if (pop_ok) st_d = ST_PART;    // UNFILL
            end
            default: st_d = ST_OFF;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        room     = 1'b1;
        holds    = 1'b0;
        st_full  = 1'b0;
        st_empty = 1'b1;
        unique case (st_q)
            ST_OFF, ST_EMPTY: begin
                room     = 1'b1;
                holds    = 1'b0;
                st_empty = 1'b1;
            end
            ST_PART: begin
                room     = 1'b1;
                holds    = 1'b1;
                st_empty = 1'b0;
            end
            ST_FULL: begin
                room     = 1'b0;
                holds    = 1'b1;
                st_full  = 1'b1;
                st_empty = 1'b0;
            end
            default: ;
        endcase
        push_ok = push_valid & ~shut & room;
        pop_ok  = pop_req & ~shut & holds;
        drop    = push_valid & ~shut & ~room;
        flush   = shut;
    end

    // unread-record counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (shut) begin
            cnt <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/txhist_flags.sv
module txhist_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_rst,
    input  logic irq_event,
    input  logic drop,
    input  logic wr_en,
    input  logic wr_irq_bit,
    input  logic wr_ovf_bit,
    output logic irq_flag,
    output logic ovf_flag
);
    logic clr_irq;
    logic clr_ovf;

    assign clr_irq = wr_en & ~wr_irq_bit;
    assign clr_ovf = wr_en & ~wr_ovf_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else if (chan_rst) begin
            irq_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (irq_event)    irq_flag <= 1'b1;
            else if (clr_irq) irq_flag <= 1'b0;
            if (drop)         ovf_flag <= 1'b1;
            else if (clr_ovf) ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/txhist_fifo.sv
module txhist_fifo
    import txhist_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              chan_rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    input  logic              irq_event,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       status
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_ok, pop_ok, drop, flush;
    logic             st_full, st_empty;
    logic [CNT_W-1:0] cnt;
    logic             irq_flag, ovf_flag;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[15:4], wr_data[1:0]};

    txhist_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .chan_rst   (chan_rst),
        .push_valid (push_valid),
        .pop_req    (pop_req),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .drop       (drop),
        .flush      (flush),
        .st_full    (st_full),
        .st_empty   (st_empty),
        .cnt        (cnt)
    );

    txhist_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (push_ok),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .rd_data (pop_data)
    );

    txhist_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_rst   (chan_rst),
        .irq_event  (irq_event),
        .drop       (drop),
        .wr_en      (wr_en),
        .wr_irq_bit (wr_data[B_IRQ]),
        .wr_ovf_bit (wr_data[B_OVF]),
        .irq_flag   (irq_flag),
        .ovf_flag   (ovf_flag)
    );

    always_comb begin
        status                              = '0;
        status[CNT_LSB +: CNT_FIELD]        = CNT_FIELD'(cnt);
        status[B_IRQ]                       = irq_flag;
        status[B_OVF]                       = ovf_flag;
        status[B_FULL]                      = st_full;
        status[B_EMPTY]                     = st_empty;
    end

endmodule

// File: rtl/txhist_fifo_chk.sv
module txhist_fifo_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        chan_rst,
    input logic        push_valid,
    input logic        irq_event,
    input logic        wr_en,
    input logic        wr_irq_bit,
    input logic        wr_ovf_bit,
    input logic [15:0] status
);
    logic [4:0] cnt5;
    assign cnt5 = {1'b0, status[11:8]};

    a_r4_full_iff_count: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] == (status[11:8] == 4'(DEPTH)));

    a_r5_empty_iff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == (status[11:8] == 4'd0));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !chan_rst) |=> (cnt5 <= $past(cnt5) + 5'd1) && ($past(cnt5) <= cnt5 + 5'd1));

    a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && push_valid && enable && !chan_rst) |=> status[2]);

    a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_event && !chan_rst) |=> status[3]);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !chan_rst && !(wr_en && !wr_irq_bit)) |=> status[3]);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !chan_rst && !(wr_en && !wr_ovf_bit)) |=> status[2]);

    a_r9_chanrst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (status == 16'h0001));

    a_r10_disable_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !chan_rst) |=> (status[11:8] == 4'd0 && status[0] && !status[1]));

endmodule

bind txhist_fifo txhist_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .chan_rst   (chan_rst),
    .push_valid (push_valid),
    .irq_event  (irq_event),
    .wr_en      (wr_en),
    .wr_irq_bit (wr_data[3]),
    .wr_ovf_bit (wr_data[2]),
    .status     (status)
);

// File: tb/sim_txhist_fifo.sv
module sim_txhist_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          chan_rst = 1'b0;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] pop_data;
    logic          irq_event = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   status;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txhist_fifo #(.DATA_W(DW), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .chan_rst(chan_rst),
        .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
        .pop_data(pop_data), .irq_event(irq_event), .wr_en(wr_en),
        .wr_data(wr_data), .status(status)
    );

    function automatic logic [15:0] stat(input int n, input logic irq, input logic ovf);
        return {4'b0, 4'(n), 4'b0, irq, ovf, (n == DP), (n == 0)};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        push_valid = 1'b1;
        push_data  = d;
        step();
        push_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [DW-1:0] exp);
        chk(req, "head record", pop_data, exp);
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic clean();
        chan_rst = 1'b1;
        step();
        chan_rst = 1'b0;
        enable   = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R1", "status after reset", status, 16'h0001);
    endtask

    task automatic t_fill_drain();
        clean();
        for (int i = 0; i < DP; i++) begin
            push(16'hA000 + 16'(i));
            chk("R3", "count while filling", status, stat(i + 1, 0, 0));
        end
        chk("R4", "full at depth", status[1], 1'b1);
        for (int i = 0; i < DP; i++) begin
            pop_expect("R2", 16'hA000 + 16'(i));
            chk("R4", "count while draining", status, stat(DP - 1 - i, 0, 0));
        end
        chk("R5", "empty after drain", status[0], 1'b1);
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
        chk("R5", "pop on empty ignored", status, stat(0, 0, 0));
    endtask

    task automatic t_push_pop_same();
        clean();
        push(16'hB000);
        push(16'hB001);
        push(16'hB002);
        push_valid = 1'b1; push_data = 16'hB003; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        chk("R3", "count kept on push+pop", status, stat(3, 0, 0));
        pop_expect("R2", 16'hB001);
        pop_expect("R2", 16'hB002);
        pop_expect("R2", 16'hB003);
        push_valid = 1'b1; push_data = 16'hB00F; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        chk("R5", "push+pop on empty stores one", status, stat(1, 0, 0));
        chk("R5", "push+pop on empty head", pop_data, 16'hB00F);
    endtask

    task automatic t_overflow();
        clean();
        for (int i = 0; i < DP; i++) push(16'hC000 + 16'(i));
        push(16'hBEEF);
        chk("R6", "overflow on full push", status, stat(DP, 0, 1));
        push_valid = 1'b1; push_data = 16'hDEAD; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        chk("R6", "full push+pop drops push", status, stat(DP - 1, 0, 1));
        for (int i = 1; i < DP; i++) pop_expect("R6", 16'hC000 + 16'(i));
        chk("R6", "nothing extra stored", status, stat(0, 0, 1));
        host_write(16'hFFFF);
        chk("R8", "write 1 keeps overflow", status, stat(0, 0, 1));
        host_write(16'hFFFB);
        chk("R8", "write 0 clears overflow", status, stat(0, 0, 0));
        for (int i = 0; i < DP; i++) push(16'hC100 + 16'(i));
        push_valid = 1'b1; push_data = 16'h1234; wr_en = 1'b1; wr_data = 16'h0000;
        step();
        push_valid = 1'b0; wr_en = 1'b0;
        chk("R8", "overflow set wins over clear", status, stat(DP, 0, 1));
    endtask

    task automatic t_irq();
        clean();
        irq_event = 1'b1;
        step();
        irq_event = 1'b0;
        chk("R7", "irq flag set", status, stat(0, 1, 0));
        step();
        chk("R8", "irq flag sticky", status, stat(0, 1, 0));
        host_write(16'h0008);
        chk("R8", "write 1 keeps irq", status, stat(0, 1, 0));
        host_write(16'h0000);
        chk("R8", "write 0 clears irq", status, stat(0, 0, 0));
        irq_event = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
        step();
        irq_event = 1'b0; wr_en = 1'b0;
        chk("R8", "irq set wins over clear", status, stat(0, 1, 0));
    endtask

    task automatic t_chan_rst();
        clean();
        for (int i = 0; i < DP; i++) push(16'hD000 + 16'(i));
        push(16'hD0FF);
        irq_event = 1'b1;
        step();
        irq_event = 1'b0;
        chk("R9", "flags before channel reset", status, stat(DP, 1, 1));
        chan_rst = 1'b1;
        step();
        chk("R9", "channel reset clears", status, 16'h0001);
        push_valid = 1'b1; push_data = 16'hD111; irq_event = 1'b1;
        step();
        push_valid = 1'b0; irq_event = 1'b0;
        chk("R9", "held channel reset blocks push and irq", status, 16'h0001);
        chan_rst = 1'b0;
        step();
        push(16'hD222);
        chk("R9", "fresh head after channel reset", pop_data, 16'hD222);
    endtask

    task automatic t_disable();
        clean();
        push(16'hE000);
        push(16'hE001);
        push(16'hE002);
        irq_event = 1'b1;
        step();
        irq_event = 1'b0;
        enable = 1'b0;
        step();
        chk("R10", "disable empties, keeps irq", status, stat(0, 1, 0));
        push(16'hE0AA);
        chk("R10", "push while disabled ignored", status, stat(0, 1, 0));
        enable = 1'b1;
        step();
        push(16'hE055);
        chk("R10", "count after re-enable", status, stat(1, 1, 0));
        chk("R10", "old records gone", pop_data, 16'hE055);
    endtask

    task automatic t_reserved();
        clean();
        push(16'hF000);
        host_write(16'hFFFF);
        chk("R11", "write all ones", status, stat(1, 0, 0));
        host_write(16'hF0F3);
        chk("R11", "write to ro and reserved bits", status, stat(1, 0, 0));
        chk("R11", "reserved bits zero", {status[15:12], status[7:4]}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        rst_n = 1'b1;
        step();
        t_reset();
        t_fill_drain();
        t_push_pop_same();
        t_overflow();
        t_irq();
        t_chan_rst();
        t_disable();
        t_reserved();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule